// File: doc/BRIEF.md
# Overlapped-Lookup Direct-Mapped Read Cache

This block is a direct-mapped data cache whose array lookup runs in parallel with address translation. The line index and byte offset are taken only from the untranslated page-offset bits of the virtual address. The array can therefore be read in the same cycle that the translation buffer, which lies outside this block, resolves the page number. The translation result arrives on the block's inputs as a hit flag and a physical frame number. The block stores physical frame numbers as tags and compares them with the translated frame.

Each accepted read has one of three outcomes:

- **Hit.** The line is returned to the processor.
- **Memory access.** The line is absent or its tag names another frame while the translation succeeded. The block fetches the line from memory at the physical address with a request/acknowledge handshake, writes it into the array and returns it.
- **Translation needed.** Translation failed. The block raises a one-cycle request for a full page-table translation and leaves the array untouched.

The default geometry is 1024 lines of 4 bytes with 4 KB pages. The byte offset width plus the index width must not exceed the page-offset width, so the cache cannot be larger than one page per way.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address with a translation hit goes to memory. Out of reset, `rsp_valid`, `mem_req` and `xlat_req` are 0 and `req_ready` is 1.
- R2: A read is accepted on a clock edge where `req_valid` and `req_ready` are both 1. It is a hit when `tlb_hit` is 1, the indexed line is valid, and its stored tag equals `tlb_pfn`. On a hit, `rsp_valid` is 1 with the line in `rsp_data` in the cycle after acceptance, and `mem_req` stays 0.
- R3: On a miss with a translation hit, `mem_req` rises two cycles after acceptance. `mem_paddr` equals {`tlb_pfn`, `req_vaddr`[11:2], 2'b00}. Both hold until the edge where `mem_ack` is 1.
- R4: In the cycle after the acknowledge edge, `rsp_valid` is 1 with `rsp_data` equal to the `mem_rdata` sampled at that edge, and `mem_req` is 0. The line is written with this data and tag, so a later read of it hits.
- R5: When `tlb_hit` is 0, `xlat_req` is 1 for exactly the cycle after acceptance, with `xlat_vpn` = `req_vaddr`[31:12]. No memory request and no response occur, and the array is unchanged even if the line was present.
- R6: A read whose index matches a valid line but whose `tlb_pfn` differs from the stored tag is treated as a miss. The fill replaces the tag, after which reads using the old frame miss.
- R7: The line index is `req_vaddr`[11:2], taken before translation. Two virtual addresses with different page numbers, the same page offset and the same frame hit the same line.
- R8: `req_ready` is 0 from the cycle after acceptance until the cycle after the response or translation request. A `req_valid` presented while `req_ready` is 0 is ignored and raises neither `xlat_req` nor any response.
- R9: Byte offset bits `req_vaddr`[1:0] do not select the line. Addresses that differ only in these bits return the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request |
| req_vaddr | input | 32 | Virtual address of the read |
| req_ready | output | 1 | Block can accept a read this cycle |
| tlb_hit | input | 1 | Translation succeeded for `req_vaddr` |
| tlb_pfn | input | 20 | Translated physical frame number |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Returned line |
| xlat_req | output | 1 | Full translation needed |
| xlat_vpn | output | 20 | Virtual page number needing translation |
| mem_req | output | 1 | Memory line read request |
| mem_paddr | output | 32 | Line-aligned physical address |
| mem_ack | input | 1 | Memory has the line on `mem_rdata` |
| mem_rdata | input | 32 | Line data from memory |

## Verification
Hit data and translation requests are due one cycle after the accepting edge. A memory request is due two cycles after it. Fill data is due one cycle after the acknowledge edge, and `req_ready` returns one cycle after that. Each scenario task drives inputs on the falling edge and counts rising edges from the accepting one. It samples every output on the falling edge where the result is due, and also checks that the other outcomes stay silent in that same cycle. Acknowledge delays of zero and several cycles, and requests presented while busy, show that the timing follows the handshake and not a fixed latency.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Control sequence of one read: accept, compare, optional fill, return.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2,
        ST_DONE = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/vipt_line_array.sv
module vipt_line_array #(
    parameter int LINES  = 1024,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);

    logic [LINES-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } rd_word_t;

    rd_word_t rd_d, rd_q;

    always_comb begin
        valid_d = valid_q;
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
        end
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.valid = valid_q[rd_idx];
            rd_d.tag   = tag_mem[rd_idx];
            rd_d.data  = data_mem[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rd_q    <= '0;
        end else begin
            valid_q <= valid_d;
            rd_q    <= rd_d;
        end
    end

    // Tag and data storage carry no reset; the valid vector guards them.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_tag   = rd_q.tag;
    assign rd_data  = rd_q.data;

    // R8
    rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int OFS_W     = 2,
    parameter int IDX_W     = 10,
    parameter int DATA_W    = 32,
    localparam int TAG_W    = PA_W - PAGE_BITS,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int KEEP_W   = VA_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KEEP_W-1:0] req_line_va,
    output logic              req_ready,
    input  logic              tlb_hit,
    input  logic [TAG_W-1:0]  tlb_pfn,
    output logic              arr_rd_en,
    output logic [IDX_W-1:0]  arr_rd_idx,
    input  logic              line_valid,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              arr_wr_en,
    output logic [IDX_W-1:0]  arr_wr_idx,
    output logic [TAG_W-1:0]  arr_wr_tag,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              xlat_req,
    output logic [VPN_W-1:0]  xlat_vpn,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_paddr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    typedef struct packed {
        ctl_state_e        state;
        logic [KEEP_W-1:0] va;
        logic              tlb_hit;
        logic [TAG_W-1:0]  pfn;
        logic [DATA_W-1:0] fill;
    } ctl_t;

    ctl_t s_d, s_q;
    logic accept;
    logic tag_match;

    always_comb begin
        s_d         = s_q;
        accept      = req_valid && (s_q.state == ST_IDLE);
        tag_match   = line_valid && (line_tag == s_q.pfn);
        req_ready   = (s_q.state == ST_IDLE);
        arr_rd_en   = accept;
        arr_rd_idx  = req_line_va[IDX_W-1:0];
        arr_wr_en   = 1'b0;
        arr_wr_idx  = s_q.va[IDX_W-1:0];
        arr_wr_tag  = s_q.pfn;
        arr_wr_data = s_q.fill;
        rsp_valid   = 1'b0;
        rsp_data    = '0;
        xlat_req    = 1'b0;
        xlat_vpn    = s_q.va[KEEP_W-1:PAGE_BITS-OFS_W];
        mem_req     = 1'b0;
        mem_paddr   = {s_q.pfn, s_q.va[PAGE_BITS-OFS_W-1:0], {OFS_W{1'b0}}};

        unique case (s_q.state)
            ST_IDLE: begin
                if (accept) begin
                    s_d.state   = ST_LOOK;
                    s_d.va      = req_line_va;
                    s_d.tlb_hit = tlb_hit;
                    s_d.pfn     = tlb_pfn;
                end
            end
            ST_LOOK: begin
                if (!s_q.tlb_hit) begin
                    xlat_req  = 1'b1;
                    s_d.state = ST_IDLE;
                end else if (tag_match) begin
                    rsp_valid = 1'b1;
                    rsp_data  = line_data;
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_d.fill  = mem_rdata;
                    s_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                arr_wr_en = 1'b1;
                rsp_valid = 1'b1;
                rsp_data  = s_q.fill;
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_paddr)));

    // R4
    fill_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (rsp_valid && !mem_req));

    // R5
    xlat_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req |-> (!mem_req && !rsp_valid));

    // R5
    xlat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req |=> !xlat_req);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rsp_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BITS  = 12,
    parameter int LINE_BYTES = 4,
    parameter int LINES      = 1024,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(LINES),
    localparam int DATA_W    = 8 * LINE_BYTES,
    localparam int TAG_W     = PA_W - PAGE_BITS,
    localparam int VPN_W     = VA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    input  logic              tlb_hit,
    input  logic [TAG_W-1:0]  tlb_pfn,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              xlat_req,
    output logic [VPN_W-1:0]  xlat_vpn,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_paddr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              arr_rd_en;
    logic [IDX_W-1:0]  arr_rd_idx;
    logic              arr_wr_en;
    logic [IDX_W-1:0]  arr_wr_idx;
    logic [TAG_W-1:0]  arr_wr_tag;
    logic [DATA_W-1:0] arr_wr_data;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;

    vipt_ctrl #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .PAGE_BITS (PAGE_BITS),
        .OFS_W     (OFS_W),
        .IDX_W     (IDX_W),
        .DATA_W    (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_line_va (req_vaddr[VA_W-1:OFS_W]),
        .req_ready   (req_ready),
        .tlb_hit     (tlb_hit),
        .tlb_pfn     (tlb_pfn),
        .arr_rd_en   (arr_rd_en),
        .arr_rd_idx  (arr_rd_idx),
        .line_valid  (line_valid),
        .line_tag    (line_tag),
        .line_data   (line_data),
        .arr_wr_en   (arr_wr_en),
        .arr_wr_idx  (arr_wr_idx),
        .arr_wr_tag  (arr_wr_tag),
        .arr_wr_data (arr_wr_data),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .xlat_req    (xlat_req),
        .xlat_vpn    (xlat_vpn),
        .mem_req     (mem_req),
        .mem_paddr   (mem_paddr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata)
    );

    vipt_line_array #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (arr_rd_en),
        .rd_idx   (arr_rd_idx),
        .wr_en    (arr_wr_en),
        .wr_idx   (arr_wr_idx),
        .wr_tag   (arr_wr_tag),
        .wr_data  (arr_wr_data),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (line_data)
    );

    // R2
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(mem_req)) |-> !mem_req);

endmodule

// File: tb/test_vipt_dcache.sv
module test_vipt_dcache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        tlb_hit = 1'b0;
    logic [19:0] tlb_pfn = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        xlat_req;
    logic [19:0] xlat_vpn;
    logic        mem_req;
    logic [31:0] mem_paddr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vipt_dcache i_vipt_dcache (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .req_ready (req_ready),
        .tlb_hit   (tlb_hit),
        .tlb_pfn   (tlb_pfn),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .xlat_req  (xlat_req),
        .xlat_vpn  (xlat_vpn),
        .mem_req   (mem_req),
        .mem_paddr (mem_paddr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Present one read; returns at a falling edge right after acceptance.
    task automatic present(input logic [31:0] va, input logic th, input logic [19:0] pfn,
                           input string rq);
        @(negedge clk);
        check(rq, "req_ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        tlb_hit   = th;
        tlb_pfn   = pfn;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        tlb_hit   = 1'b0;
    endtask

    task automatic read_hit(input logic [31:0] va, input logic [19:0] pfn,
                            input logic [31:0] exp, input string rq);
        present(va, 1'b1, pfn, rq);
        check(rq, "hit rsp_valid", {31'b0, rsp_valid}, 32'd1);
        check(rq, "hit rsp_data", rsp_data, exp);
        check(rq, "hit mem_req", {31'b0, mem_req}, 32'd0);
        check(rq, "hit xlat_req", {31'b0, xlat_req}, 32'd0);
        @(negedge clk);
        check(rq, "ready after hit", {31'b0, req_ready}, 32'd1);
        check(rq, "rsp_valid drops after hit", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic read_xlat(input logic [31:0] va, input logic [19:0] pfn, input string rq);
        present(va, 1'b0, pfn, rq);
        check(rq, "xlat_req", {31'b0, xlat_req}, 32'd1);
        check(rq, "xlat_vpn", {12'b0, xlat_vpn}, {12'b0, va[31:12]});
        check(rq, "no rsp on xlat", {31'b0, rsp_valid}, 32'd0);
        check(rq, "no mem_req on xlat", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        check(rq, "xlat_req one cycle", {31'b0, xlat_req}, 32'd0);
        check(rq, "mem_req stays low after xlat", {31'b0, mem_req}, 32'd0);
        check(rq, "ready after xlat", {31'b0, req_ready}, 32'd1);
    endtask

    // Miss with translation hit; optionally hammer the block while busy.
    task automatic read_fill(input logic [31:0] va, input logic [19:0] pfn,
                             input logic [31:0] data, input int ack_wait,
                             input bit intrude, input string rq);
        present(va, 1'b1, pfn, rq);
        check(rq, "miss: no rsp in compare cycle", {31'b0, rsp_valid}, 32'd0);
        check(rq, "miss: mem_req not yet", {31'b0, mem_req}, 32'd0);
        if (intrude) begin
            req_valid = 1'b1;
            req_vaddr = va ^ 32'h0055_5010;
            tlb_hit   = 1'b0;
        end
        @(negedge clk);
        check(rq, "mem_req raised", {31'b0, mem_req}, 32'd1);
        check(rq, "mem_paddr", mem_paddr, {pfn, va[11:2], 2'b00});
        for (int i = 0; i < ack_wait; i++) begin
            @(negedge clk);
            check(rq, "mem_req held", {31'b0, mem_req}, 32'd1);
            check(rq, "mem_paddr held", mem_paddr, {pfn, va[11:2], 2'b00});
            if (intrude) begin
                check("R8", "ready low while busy", {31'b0, req_ready}, 32'd0);
                check("R8", "ignored request raises no xlat", {31'b0, xlat_req}, 32'd0);
            end
        end
        req_valid = 1'b0;
        mem_ack   = 1'b1;
        mem_rdata = data;
        @(posedge clk);
        @(negedge clk);
        mem_ack   = 1'b0;
        mem_rdata = 32'hFFFF_FFFF;
        check(rq, "fill rsp_valid", {31'b0, rsp_valid}, 32'd1);
        check(rq, "fill rsp_data", rsp_data, data);
        check(rq, "mem_req dropped", {31'b0, mem_req}, 32'd0);
        check(rq, "ready low in return cycle", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        check(rq, "ready after fill", {31'b0, req_ready}, 32'd1);
        check(rq, "rsp_valid drops after fill", {31'b0, rsp_valid}, 32'd0);
        if (intrude) begin
            check("R8", "no stray xlat after busy", {31'b0, xlat_req}, 32'd0);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "rsp_valid at reset", {31'b0, rsp_valid}, 32'd0);
        check("R1", "mem_req at reset", {31'b0, mem_req}, 32'd0);
        check("R1", "xlat_req at reset", {31'b0, xlat_req}, 32'd0);
        check("R1", "req_ready at reset", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_cold_and_hit;
        read_fill(32'h0000_1234, 20'hABCDE, 32'hDEAD_BEEF, 2, 1'b0, "R1_R3_R4");
        read_hit(32'h0000_1234, 20'hABCDE, 32'hDEAD_BEEF, "R2_R4");
        read_hit(32'h0000_1236, 20'hABCDE, 32'hDEAD_BEEF, "R9");
        read_hit(32'h0000_1237, 20'hABCDE, 32'hDEAD_BEEF, "R9");
    endtask

    task automatic t_alias;
        read_hit(32'h7777_7234, 20'hABCDE, 32'hDEAD_BEEF, "R7");
    endtask

    task automatic t_xlat;
        read_xlat(32'h0000_1234, 20'hABCDE, "R5");
        read_xlat(32'h0042_3000, 20'h00000, "R5");
        read_hit(32'h0000_1234, 20'hABCDE, 32'hDEAD_BEEF, "R5");
    endtask

    task automatic t_mismatch;
        read_fill(32'h0000_1234, 20'h12345, 32'h0BAD_F00D, 0, 1'b0, "R6");
        read_hit(32'h0000_1234, 20'h12345, 32'h0BAD_F00D, "R6");
        read_fill(32'h0000_1234, 20'hABCDE, 32'h1357_9BDF, 1, 1'b0, "R6");
    endtask

    task automatic t_busy;
        read_fill(32'h0000_0FFC, 20'h00F0F, 32'hCAFE_0001, 4, 1'b1, "R8");
        read_hit(32'h0000_0FFC, 20'h00F0F, 32'hCAFE_0001, "R8");
    endtask

    task automatic t_edges;
        read_fill(32'h0000_0000, 20'hFFFFF, 32'hA5A5_5A5A, 3, 1'b0, "R3");
        read_hit(32'h0000_0000, 20'hFFFFF, 32'hA5A5_5A5A, "R2");
        read_hit(32'h0000_0FFC, 20'h00F0F, 32'hCAFE_0001, "R2");
        read_hit(32'h0000_1234, 20'hABCDE, 32'h1357_9BDF, "R2");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_and_hit();
        t_alias();
        t_xlat();
        t_mismatch();
        t_busy();
        t_edges();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule